// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block collects single-cycle event pulses from a DMA engine into sticky status flags. Each flag has a matching mask bit in an enable register. A single registered interrupt line goes high whenever any flag is both set and enabled.

The event flags are split into two groups: a low "normal" group and a high "abnormal" group. Each group has a read-only summary flag. A summary is set while at least one enabled flag in its group is set. It drops once every enabled flag in that group has been cleared.

Software reaches the block through a plain register port with a write strobe, an address, write data and a combinational read path. Flags are cleared by writing ones to the status word. Writing zeros leaves flags untouched. When an event pulse and a clear for the same flag land in one cycle, the flag stays set.

Top module: `grp_irq_status`

## Requirements
- R1: While reset is held low, and directly after it is released, the status word, the enable word and `irqOut` all read zero.
- R2: A high level on `evtIn[i]` at a clock edge sets status flag i at that edge. The flag stays set until it is cleared by software, and no flag ever sets without its event.
- R3: A write to address 0 clears every status flag whose bit in `regWdata[NEV-1:0]` is 1. Flags whose write bit is 0 keep their value.
- R4: If an event pulse and a write-one clear hit the same flag in the same cycle, the flag is set after that edge.
- R5: Address 1 holds the enable word, which is read/write in bits [NEV-1:0]. Its upper bits read as zero.
- R6: `irqOut` is registered. After each edge it equals the OR of (status AND enable) as it stood just before that edge. In other words, it follows a change in the pending flags with one cycle of delay.
- R7: Status read bit DATA_W-1 is the normal summary. It is the OR of the enabled status flags at indices 0 to NUM_NORMAL-1.
- R8: Status read bit DATA_W-2 is the abnormal summary. It is the OR of the enabled status flags at indices NUM_NORMAL to NEV-1.
- R9: A status flag whose enable bit is 0 still latches and reads back. It has no effect on `irqOut` or on either summary.
- R10: Several kinds of write leave all state unchanged except where noted. A status write does not alter the enable word. An enable write does not clear status flags. Writes to addresses 2 and above change nothing, and reads from those addresses return zero. The summary bits ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NEV | Event pulses, normal group in the low bits |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address (0 status, 1 enable) |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Combinational read data for `regAddr` |
| irqOut | output | 1 | Registered interrupt request |

## Verification
A flag that was lost or set spuriously shows up at the status read port in the very cycle after the offending edge. It reaches `irqOut` one cycle later if that flag is enabled. A wrong enable bit stays hidden until its flag is set, and then shows as a wrong summary bit or a wrong interrupt level. Random traffic with sparse events and frequent mixed writes therefore compares both the read word and `irqOut` after every edge, so that any divergence is caught within two cycles of its cause.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   stWrite;
    logic   enWrite;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          strb
);

  logic hitStatus;
  logic hitEnable;

  assign hitStatus = (regAddr == ADDR_W'(ADDR_STATUS));
  assign hitEnable = (regAddr == ADDR_W'(ADDR_ENABLE));

  always_comb begin
    strb.stWrite = regWe && hitStatus;
    strb.enWrite = regWe && hitEnable;
    if (hitStatus)      strb.rdSel = RD_STATUS;
    else if (hitEnable) strb.rdSel = RD_ENABLE;
    else                strb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/grp_irq_datapath.sv
module grp_irq_datapath
  import grp_irq_pkg::*;
#(
  parameter int NUM_NORMAL   = 8,
  parameter int NUM_ABNORMAL = 6,
  parameter int DATA_W       = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_NORMAL+NUM_ABNORMAL-1:0]  evtIn,
  input  logic [NUM_NORMAL+NUM_ABNORMAL-1:0]  wrBits,
  input  strobes_t                            strb,
  output logic [DATA_W-1:0]                   rdData,
  output logic                                irqOut,
  output logic [NUM_NORMAL+NUM_ABNORMAL-1:0]  statusVal,
  output logic [NUM_NORMAL+NUM_ABNORMAL-1:0]  enableVal
);

  localparam int NEV    = NUM_NORMAL + NUM_ABNORMAL;
  localparam int SUM_NM = DATA_W - 1;
  localparam int SUM_AB = DATA_W - 2;

  logic [NEV-1:0] statusQ;
  logic [NEV-1:0] enableQ;
  logic [NEV-1:0] clrMask;
  logic [NEV-1:0] pending;
  logic           normSum;
  logic           abnSum;
  logic           irqQ;

  assign clrMask = strb.stWrite ? wrBits : '0;

  // one sticky flop per event; the set term is ORed in after the clear
  for (genvar i = 0; i < NEV; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= (statusQ[i] & ~clrMask[i]) | evtIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             enableQ <= '0;
    else if (strb.enWrite) enableQ <= wrBits;
  end

  assign pending = statusQ & enableQ;
  assign normSum = |pending[NUM_NORMAL-1:0];
  assign abnSum  = |pending[NEV-1:NUM_NORMAL];

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= normSum | abnSum;
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_STATUS: begin
        rdData[NEV-1:0] = statusQ;
        rdData[SUM_NM]  = normSum;
        rdData[SUM_AB]  = abnSum;
      end
      RD_ENABLE: rdData[NEV-1:0] = enableQ;
      default:   rdData = '0;
    endcase
  end

  assign irqOut    = irqQ;
  assign statusVal = statusQ;
  assign enableVal = enableQ;

endmodule

// File: rtl/grp_irq_status.sv
module grp_irq_status
  import grp_irq_pkg::*;
#(
  parameter int NUM_NORMAL   = 8,
  parameter int NUM_ABNORMAL = 6,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_NORMAL+NUM_ABNORMAL-1:0] evtIn,
  input  logic                               regWe,
  input  logic [ADDR_W-1:0]                  regAddr,
  input  logic [DATA_W-1:0]                  regWdata,
  output logic [DATA_W-1:0]                  regRdata,
  output logic                               irqOut
);

  localparam int NEV = NUM_NORMAL + NUM_ABNORMAL;

  strobes_t       strb;
  logic [NEV-1:0] statusVal;
  logic [NEV-1:0] enableVal;
  logic           unusedHiBits;

  assign unusedHiBits = ^regWdata[DATA_W-1:NEV];

  grp_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strb    (strb)
  );

  grp_irq_datapath #(
    .NUM_NORMAL   (NUM_NORMAL),
    .NUM_ABNORMAL (NUM_ABNORMAL),
    .DATA_W       (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .wrBits    (regWdata[NEV-1:0]),
    .strb      (strb),
    .rdData    (regRdata),
    .irqOut    (irqOut),
    .statusVal (statusVal),
    .enableVal (enableVal)
  );

endmodule

// File: rtl/grp_irq_checker.sv
module grp_irq_checker #(
  parameter int NEV    = 14,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NEV-1:0]    evtIn,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              irqOut,
  input logic [NEV-1:0]    statusVal,
  input logic [NEV-1:0]    enableVal
);

  logic           stWr;
  logic           enWr;
  logic [NEV-1:0] wrLow;
  logic           unusedChk;

  assign stWr      = regWe && (regAddr == ADDR_W'(0));
  assign enWr      = regWe && (regAddr == ADDR_W'(1));
  assign wrLow     = regWdata[NEV-1:0];
  assign unusedChk = ^regWdata[DATA_W-1:NEV];

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((statusVal & $past(evtIn)) == $past(evtIn)));

  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusVal & ~$past(statusVal) & ~$past(evtIn)) == '0));

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stWr |=> ((~statusVal & $past(statusVal)) == '0));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    stWr |=> ((statusVal & $past(wrLow & ~evtIn)) == '0));

  p_enable_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enWr |=> $stable(enableVal));

  p_irq_lag_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusVal & enableVal))));

endmodule

bind grp_irq_status grp_irq_checker #(
  .NEV    (NEV),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtIn     (evtIn),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .irqOut    (irqOut),
  .statusVal (statusVal),
  .enableVal (enableVal)
);

// File: tb/sim_grp_irq_status.sv
`timescale 1ns/1ps
module sim_grp_irq_status;

  localparam int NN  = 8;
  localparam int NA  = 6;
  localparam int NEV = NN + NA;
  localparam int DW  = 32;
  localparam int AW  = 2;

  logic           clk = 1'b0;
  logic           rstN;
  logic [NEV-1:0] evtIn;
  logic           regWe;
  logic [AW-1:0]  regAddr;
  logic [DW-1:0]  regWdata;
  logic [DW-1:0]  regRdata;
  logic           irqOut;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [NEV-1:0] stM;
  logic [NEV-1:0] enM;
  logic           irqM;

  always #2.5 clk = ~clk;

  grp_irq_status #(
    .NUM_NORMAL(NN), .NUM_ABNORMAL(NA), .DATA_W(DW), .ADDR_W(AW)
  ) u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    logic [NEV-1:0] p;
    r = '0;
    p = stM & enM;
    if (a == 0) begin
      r[NEV-1:0] = stM;
      r[DW-1]    = |p[NN-1:0];
      r[DW-2]    = |p[NEV-1:NN];
    end else if (a == 1) begin
      r[NEV-1:0] = enM;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NEV-1:0] e, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    evtIn = e; regWe = we; regAddr = a; regWdata = d;
    @(posedge clk);
    irqM = |(stM & enM);
    if (we && a == 0) stM = stM & ~d[NEV-1:0];
    stM = stM | e;
    if (we && a == 1) enM = d[NEV-1:0];
    #1;
    chk("R6 irqOut", {31'b0, irqOut}, {31'b0, irqM});
    chk(tag, regRdata, expRead(a));
  endtask

  task automatic look(input logic [AW-1:0] a, input string tag);
    step('0, 1'b0, a, '0, tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; evtIn = '0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    stM = '0; enM = '0; irqM = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq in reset", {31'b0, irqOut}, '0);
    chk("R1 status in reset", regRdata, '0);
    regAddr = 1;
    #1;
    chk("R1 enable in reset", regRdata, '0);
    rstN = 1'b1;
    look(0, "R1 status after reset");
    look(1, "R1 enable after reset");

    // disabled flag latches, no irq
    step(14'h0008, 1'b0, 0, '0, "R2 event sets flag");
    look(0, "R2 flag sticky");
    look(0, "R9 disabled flag no summary");
    chk("R9 no irq when disabled", {31'b0, irqOut}, '0);

    // enable all, upper bits read zero
    step('0, 1'b1, 1, 32'hFFFF_FFFF, "R5 enable write");
    look(1, "R5 enable upper bits zero");
    look(0, "R7 normal summary");
    chk("R6 irq asserted", {31'b0, irqOut}, 32'd1);
    look(1, "R10 status reads kept enable");

    // zero write no effect, then clear
    step('0, 1'b1, 0, 32'h0, "R3 write zero keeps flags");
    step('0, 1'b1, 0, 32'h0000_0008, "R3 write one clears");
    look(0, "R6 irq drops");
    chk("R6 irq low", {31'b0, irqOut}, '0);

    // set wins over clear, abnormal group
    step(14'h0400, 1'b0, 0, '0, "R8 abnormal event");
    step(14'h0400, 1'b1, 0, 32'h0000_0400, "R4 set wins");
    look(0, "R8 abnormal summary");
    step('0, 1'b1, 1, 32'h0000_00FF, "R9 mask abnormal");
    look(0, "R8 summary drops when masked");
    step('0, 1'b1, 0, 32'hC000_0000, "R10 summary write ignored");

    // unmapped addresses
    step('0, 1'b1, 2, 32'hFFFF_FFFF, "R10 unmapped reads zero");
    step('0, 1'b1, 3, 32'hFFFF_FFFF, "R10 unmapped reads zero");
    look(0, "R10 status unchanged");
    look(1, "R10 enable unchanged");
    step('0, 1'b1, 1, 32'h0000_3FFF, "R10 enable write keeps status");
    look(0, "R10 status after enable write");

    for (int n = 0; n < 3000; n++) begin
      logic [NEV-1:0] e;
      logic we;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      e  = NEV'($urandom & $urandom & $urandom & $urandom);
      we = ($urandom % 3) == 0;
      a  = AW'($urandom % 4);
      d  = $urandom;
      step(e, we, a, d, "random R2 R3 R4 R7 R8 R9");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule